// File: doc/BRIEF.md
# Sample Rate Clock Divider

This block turns a fast generator clock into the two timing signals an oversampling converter bank needs: a converter master clock enable, pulsing once every `Ndiv` generator cycles, and a per-channel sample strobe, pulsing once every `Ndiv × OSR` generator cycles. `Ndiv` is an 8-bit rate divisor held in a register. `OSR` is the oversampling ratio, set by a 2-bit mode input.

Mode 0 is the normal generator-clock path. It uses an oversampling ratio of 512, so the sample rate is the generator frequency divided by 512 × `Ndiv`. For example, a 31,457,280 Hz generator with a divisor of 4 gives 15,360 samples per second. Modes 1 to 3 serve a directly applied external clock. They select ratios of 256, 128 and 64, for the 2–50, 50–100 and 100–200 ksps bands.

Any write to the divisor, and any change of mode, restarts both counters from zero. A partial period therefore never produces a strobe. The useful divisor range is 0 to 25, and a divisor of 0 behaves as 1.

Top module: `srd_rate_divider`

## Requirements
- R1: After reset the divisor register reads 5, and `mclk_o` and `sample_o` are low.
- R2: The divisor occupies bits 7:0 of the 32-bit register. Bits 31:8 of a write are ignored and read back as zero. A written value reads back from the cycle after the write.
- R3: `sample_o` pulses every `Ndiv × OSR` generator cycles. The first pulse comes exactly `Ndiv × OSR` rising edges after reset release or after a restart edge. With mode 0 and divisor 4, the period is 2048 cycles.
- R4: A divisor of 0 behaves as 1. `mclk_o` then pulses on every cycle, and the sample period equals OSR.
- R5: `mclk_o` is a one-cycle pulse every `Ndiv` cycles. A sample period contains exactly OSR such pulses.
- R6: `mode_i` encodes the oversampling ratio as follows: 0 gives 512, 1 gives 256, 2 gives 128, 3 gives 64.
- R7: `sample_o` is high for exactly one cycle, and only in a cycle in which `mclk_o` is also high.
- R8: The rising edge that captures a divisor write clears both counters. No strobe appears at that edge, and the next strobe comes one full new period later.
- R9: A change of `mode_i` restarts the counters in the same way as a divisor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generator or external clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_we_i | input | 1 | Divisor register write strobe |
| div_wdata_i | input | 32 | Write data; divisor in bits 7:0 |
| div_rdata_o | output | 32 | Divisor register read value |
| mode_i | input | 2 | Oversampling ratio select |
| mclk_o | output | 1 | Converter master clock enable pulse |
| sample_o | output | 1 | Per-channel sample strobe |

## Verification
The hardest case to reach from the ports is a restart in the middle of a period. The bench must show that a partly counted period is discarded and that no early strobe leaks out. To get there, the bench lets the counters run several hundred cycles into a period and then writes a new divisor or switches the mode. It then counts edges from the restart edge to the next strobe and expects exactly one full new period. A zero divisor is also exercised, so that the one-cycle master-clock case is covered.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int unsigned OSR_LOG2_MAX = 9;   // largest ratio 512
  localparam int unsigned MODE_W       = 2;

  typedef enum logic [MODE_W-1:0] {
    OSR_512 = 2'd0,
    OSR_256 = 2'd1,
    OSR_128 = 2'd2,
    OSR_64  = 2'd3
  } osr_mode_e;
endpackage

// File: rtl/srd_rate_reg.sv
module srd_rate_reg #(
  parameter int unsigned REG_W = 32,
  parameter int unsigned DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [DIV_W-1:0] ndiv_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = REG_W - DIV_W;

  logic [DIV_W-1:0] ndiv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ndiv_q <= DIV_RST;
    else if (we_i) ndiv_q <= wdata_i[DIV_W-1:0];
  end

  assign ndiv_o  = ndiv_q;
  assign rdata_o = {{PAD_W{1'b0}}, ndiv_q};

  assert_write_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ndiv_q == $past(wdata_i[DIV_W-1:0]));
endmodule

// File: rtl/srd_prescaler.sv
module srd_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] ndiv_i,
  output logic             wrap_o,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff;
  logic [DIV_W-1:0] last;

  // zero divisor runs as one so the chain never stalls
  assign eff    = (ndiv_i == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : ndiv_i;
  assign last   = eff - {{(DIV_W-1){1'b0}}, 1'b1};
  assign wrap_o = (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= wrap_o ? '0 : cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
      tick_o <= wrap_o;
    end
  end

  assert_zero_div_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ndiv_i == '0 && !restart_i) |=> tick_o);

  assert_restart_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !tick_o);
endmodule

// File: rtl/srd_os_counter.sv
module srd_os_counter
  import srd_pkg::*;
#(
  parameter int unsigned OSR_W = OSR_LOG2_MAX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              step_i,
  input  osr_mode_e         mode_i,
  output logic              sample_o
);
  logic [OSR_W:0]   osr_full;
  logic [OSR_W-1:0] os_last;
  logic [OSR_W-1:0] cnt_q;
  logic             at_last;

  assign osr_full = {1'b1, {OSR_W{1'b0}}} >> mode_i;
  assign os_last  = osr_full[OSR_W-1:0] - {{(OSR_W-1){1'b0}}, 1'b1};
  assign at_last  = (cnt_q == os_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      sample_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q    <= '0;
      sample_o <= 1'b0;
    end else begin
      sample_o <= step_i && at_last;
      if (step_i) cnt_q <= at_last ? '0 : cnt_q + {{(OSR_W-1){1'b0}}, 1'b1};
    end
  end

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
endmodule

// File: rtl/srd_rate_divider.sv
module srd_rate_divider
  import srd_pkg::*;
#(
  parameter int unsigned REG_W = 32,
  parameter int unsigned DIV_W = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [REG_W-1:0] div_wdata_i,
  output logic [REG_W-1:0] div_rdata_o,
  input  logic [1:0]       mode_i,
  output logic             mclk_o,
  output logic             sample_o
);
  logic [DIV_W-1:0] ndiv;
  logic             pre_wrap;
  logic             restart;
  osr_mode_e        mode_q;
  osr_mode_e        mode_in;

  assign mode_in = osr_mode_e'(mode_i);
  assign restart = div_we_i || (mode_in != mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= OSR_512;
    else         mode_q <= mode_in;
  end

  srd_rate_reg #(.REG_W(REG_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (div_we_i),
    .wdata_i (div_wdata_i),
    .ndiv_o  (ndiv),
    .rdata_o (div_rdata_o)
  );

  srd_prescaler #(.DIV_W(DIV_W)) i_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .ndiv_i    (ndiv),
    .wrap_o    (pre_wrap),
    .tick_o    (mclk_o)
  );

  srd_os_counter #(.OSR_W(OSR_LOG2_MAX)) i_os (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .step_i    (pre_wrap),
    .mode_i    (mode_in),
    .sample_o  (sample_o)
  );

  assert_sample_on_mclk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> mclk_o);
endmodule

// File: tb/test_srd_rate_divider.sv
module test_srd_rate_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  mode = 2'd0;
  logic        mclk;
  logic        sample;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #10 clk = ~clk;   // 50 MHz

  srd_rate_divider i_srd_rate_divider (
    .clk_i(clk), .rst_ni(rst_n), .div_we_i(we), .div_wdata_i(wdata),
    .div_rdata_o(rdata), .mode_i(mode), .mclk_o(mclk), .sample_o(sample)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts edges from the current negedge to the next strobe, and mclk pulses seen
  task automatic wait_sample(output int n, output int nm);
    n = 0; nm = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (mclk) nm++;
    end while (!sample && n < 140000);
  endtask

  task automatic write_div(input logic [31:0] v);
    @(negedge clk); we = 1'b1; wdata = v;
    @(posedge clk);
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    int n, nm;
    @(negedge clk);
    check("R1 divisor", rdata, 5);
    check("R1 mclk", mclk, 0);
    check("R1 sample", sample, 0);
    rst_n = 1'b1;
    wait_sample(n, nm);
    check("R3 first period default", n, 2560);
    check("R5 mclk per period default", nm, 512);
  endtask

  task automatic t_mclk_period;
    int n = 0;
    do begin @(posedge clk); n++; @(negedge clk); end while (!mclk && n < 100);
    check("R5 mclk spacing", n, 5);
    @(negedge clk);
    check("R7 sample one cycle", sample, 0);
  endtask

  task automatic t_worked_case;
    int n, nm;
    write_div(32'd4);
    check("R2 readback", rdata, 4);
    wait_sample(n, nm);
    check("R3 first period div4", n, 2048);
    wait_sample(n, nm);
    check("R3 steady period div4", n, 2048);
    check("R5 mclk count div4", nm, 512);
  endtask

  task automatic t_reserved;
    write_div(32'hFFFF_FF03);
    check("R2 upper bits ignored", rdata, 3);
  endtask

  task automatic t_modes;
    int n, nm;
    write_div(32'd2);
    set_mode(2'd1);
    wait_sample(n, nm);
    check("R6 mode1 period", n, 512);
    set_mode(2'd2);
    wait_sample(n, nm);
    check("R6 mode2 period", n, 256);
    set_mode(2'd3);
    wait_sample(n, nm);
    check("R6 mode3 period", n, 128);
    check("R5 mclk count mode3", nm, 64);
  endtask

  task automatic t_zero_div;
    int n, nm;
    write_div(32'd0);
    wait_sample(n, nm);
    check("R4 zero div period", n, 64);
    check("R4 mclk every cycle", nm, 64);
    @(negedge clk);
    check("R7 sample drops", sample, 0);
  endtask

  task automatic t_top_divisor;
    int n, nm;
    write_div(32'd25);
    wait_sample(n, nm);
    check("R3 divisor 25 mode3", n, 1600);
  endtask

  task automatic t_write_midway;
    int n, nm;
    set_mode(2'd0);
    write_div(32'd4);
    idle(1000);
    write_div(32'd3);
    wait_sample(n, nm);
    check("R8 restart after write", n, 1536);
  endtask

  task automatic t_mode_midway;
    int n, nm;
    write_div(32'd2);
    idle(300);
    set_mode(2'd2);
    wait_sample(n, nm);
    check("R9 restart after mode change", n, 256);
  endtask

  initial begin
    t_reset();
    t_mclk_period();
    t_worked_case();
    t_reserved();
    t_modes();
    t_zero_div();
    t_top_divisor();
    t_write_midway();
    t_mode_midway();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule